// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Multiplexed Row/Column Address

This controller connects a host that makes single-bit accesses to a DRAM-style array of 2048 x 2048 one-bit cells. The array has only eleven address pins, and they are shared between the row number and the column number. The host presents a flat 22-bit bit address, a direction flag and one bit of write data, using a valid/ready handshake. The controller splits the address: the upper eleven bits give the row and the lower eleven bits give the column. It drives the row on the shared pins under an active-low row strobe, then drives the column under an active-low column strobe. After the access it leaves the row open.

A later request to the open row goes straight to the column phase. A request to a different row first closes the open row for a precharge period whose length is a parameter, and then opens the new row. A read holds the column strobe for one cycle. The array keeps the selected bit latched after the column strobe rises, and the controller pulls output enable low for one more cycle to take that bit. The bit returns to the host with a one-cycle valid pulse. A free-running timer marks a refresh as due at a fixed interval. When one is due, the controller closes any open row and strobes the next refresh row with the row strobe alone before it accepts more host work. Every output is driven from a register.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is active, and in the cycle after it, mem_ras_n, mem_cas_n, mem_we_n and mem_oe_n are all 1, rsp_valid is 0 and req_ready is 1.
- R2: A request accepted while no row is open gives mem_ras_n=0 with the row (req_addr[21:11]) on mem_addr in the next cycle. In the cycle after that it gives mem_cas_n=0 with the column (req_addr[10:0]) on mem_addr.
- R3: A request accepted while its row is already open skips the row phase. mem_cas_n goes low with the column in the cycle after acceptance, and mem_ras_n stays low.
- R4: A request to a row other than the open one raises mem_ras_n for exactly PRE_CYC cycles (PRE_CYC is at least 2) before the new row strobe.
- R5: A write drives mem_we_n=0 and mem_wdata=req_wdata in exactly the one cycle in which mem_cas_n is low. The controller is ready again one cycle after that.
- R6: A read holds mem_cas_n low for one cycle. In the next cycle mem_cas_n=1 and mem_oe_n=0. In the cycle after that rsp_valid is high for one cycle and rsp_rdata carries the stored bit. mem_oe_n is never low while mem_cas_n is low.
- R7: Every REF_INTERVAL clock cycles a refresh becomes due. The controller closes any open row (precharge of PRE_CYC cycles) and gives one cycle of mem_ras_n=0 with mem_cas_n=1. mem_addr carries a refresh row that starts at 0 and goes up by one each time, wrapping at 2048. A precharge of PRE_CYC cycles follows, and the row is left closed.
- R8: While a refresh is due or running, req_ready is 0, and the refresh is carried out before any new request is accepted.
- R9: mem_cas_n is low only while mem_ras_n is low.
- R10: A request is taken at a rising edge with req_valid=1 and req_ready=1. req_ready is then 0 until the access has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes a request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Bit address, row in upper half, column in lower half |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 1 | Read data |
| mem_addr | output | 11 | Shared row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable of the array's data latch, active low |
| mem_wdata | output | 1 | Data to the array |
| mem_rdata | input | 1 | Data from the array, valid while mem_oe_n is low |

## Verification
The bench alternates between same-row and different-row requests, including rows 0 and 2047. A design that loses track of the open row either pays a needless precharge on a page hit or strobes a column into the wrong row, and the second fault shows up as wrong read-back data. A short refresh interval makes refreshes collide with traffic, including one falling due in the very cycle a request is offered. A design that gets this wrong either lets a request jump ahead of a due refresh or refreshes without first closing the open row. Reads check that data is taken only after the column strobe has risen, since a design that samples too early returns the array's stale latch.

// File: rtl/dram_pkg.sv
package dram_pkg;
    timeunit 1ns; timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_HOLD,
        ST_PRE,
        ST_REF
    } state_e;

    typedef enum logic [1:0] {
        AFTER_ROW,
        AFTER_REF,
        AFTER_IDLE
    } pre_next_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter  int INTERVAL = 1560,
    localparam int TW       = $clog2(INTERVAL)
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    timeunit 1ns; timeprecision 1ps;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == TW'(INTERVAL - 1));
        cnt_d = tick ? '0 : cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_row_match.sv
module dram_row_match #(
    parameter int ROW_W = 11,
    parameter int COL_W = 11
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   hit
);
    timeunit 1ns; timeprecision 1ps;

    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dram_pkg::*;
#(
    parameter  int ROW_W        = 11,
    parameter  int COL_W        = 11,
    parameter  int PRE_CYC      = 2,
    parameter  int REF_INTERVAL = 1560,
    localparam int AW           = ROW_W + COL_W,
    localparam int MW           = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          req_wdata,
    output logic          rsp_valid,
    output logic          rsp_rdata,
    output logic [MW-1:0] mem_addr,
    output logic          mem_ras_n,
    output logic          mem_cas_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_wdata,
    input  logic          mem_rdata
);
    timeunit 1ns; timeprecision 1ps;

    localparam int CW = $clog2(PRE_CYC + 1);

    typedef struct packed {
        state_e           st;
        pre_next_e        nxt;
        logic [CW-1:0]    cnt;
        logic             open;
        logic [ROW_W-1:0] open_row;
        logic             p_wr;
        logic [ROW_W-1:0] p_row;
        logic [COL_W-1:0] p_col;
        logic             p_wd;
        logic             ref_pend;
        logic [ROW_W-1:0] ref_row;
        logic             ready;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic [MW-1:0]    addr;
        logic             wdata;
        logic             rsp_v;
        logic             rsp_d;
    } ctl_t;

    ctl_t d, q;

    logic             ref_tick;
    logic             start_ref;
    logic [ROW_W-1:0] a_row;
    logic [COL_W-1:0] a_col;
    logic             row_hit;

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    dram_row_match #(.ROW_W(ROW_W), .COL_W(COL_W)) u_match (
        .addr    (req_addr),
        .open_row(q.open_row),
        .row     (a_row),
        .col     (a_col),
        .hit     (row_hit)
    );

    always_comb begin
        d         = q;
        d.rsp_v   = 1'b0;
        start_ref = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && q.ready) begin
                    d.p_wr  = req_write;
                    d.p_row = a_row;
                    d.p_col = a_col;
                    d.p_wd  = req_wdata;
                    if (q.open && row_hit) begin
                        d.st    = ST_COL;
                        d.cas_n = 1'b0;
                        d.addr  = MW'(a_col);
                        d.we_n  = ~req_write;
                        d.wdata = req_wdata;
                    end else if (q.open) begin
                        d.st    = ST_PRE;
                        d.nxt   = AFTER_ROW;
                        d.cnt   = CW'(PRE_CYC - 1);
                        d.ras_n = 1'b1;
                        d.open  = 1'b0;
                    end else begin
                        d.st       = ST_ROW;
                        d.ras_n    = 1'b0;
                        d.addr     = MW'(a_row);
                        d.open     = 1'b1;
                        d.open_row = a_row;
                    end
                end else if (q.ref_pend) begin
                    start_ref = 1'b1;
                    if (q.open) begin
                        d.st    = ST_PRE;
                        d.nxt   = AFTER_REF;
                        d.cnt   = CW'(PRE_CYC - 1);
                        d.ras_n = 1'b1;
                        d.open  = 1'b0;
                    end else begin
                        d.st    = ST_REF;
                        d.ras_n = 1'b0;
                        d.addr  = MW'(q.ref_row);
                    end
                end
            end
            ST_ROW: begin
                d.st    = ST_COL;
                d.cas_n = 1'b0;
                d.addr  = MW'(q.p_col);
                d.we_n  = ~q.p_wr;
                d.wdata = q.p_wd;
            end
            ST_COL: begin
                d.cas_n = 1'b1;
                d.we_n  = 1'b1;
                if (q.p_wr) begin
                    d.st = ST_IDLE;
                end else begin
                    d.st   = ST_HOLD;
                    d.oe_n = 1'b0;
                end
            end
            ST_HOLD: begin
                d.oe_n  = 1'b1;
                d.rsp_v = 1'b1;
                d.rsp_d = mem_rdata;
                d.st    = ST_IDLE;
            end
            ST_PRE: begin
                if (q.cnt == '0) begin
                    case (q.nxt)
                        AFTER_ROW: begin
                            d.st       = ST_ROW;
                            d.ras_n    = 1'b0;
                            d.addr     = MW'(q.p_row);
                            d.open     = 1'b1;
                            d.open_row = q.p_row;
                        end
                        AFTER_REF: begin
                            d.st    = ST_REF;
                            d.ras_n = 1'b0;
                            d.addr  = MW'(q.ref_row);
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            ST_REF: begin
                d.st      = ST_PRE;
                d.nxt     = AFTER_IDLE;
                d.cnt     = CW'(PRE_CYC - 1);
                d.ras_n   = 1'b1;
                d.ref_row = q.ref_row + ROW_W'(1);
            end
            default: d.st = ST_IDLE;
        endcase
        d.ref_pend = ref_tick | (q.ref_pend & ~start_ref);
        d.ready    = (d.st == ST_IDLE) & ~d.ref_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.nxt      <= AFTER_IDLE;
            q.ready    <= 1'b1;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 1'b1;
            q.we_n     <= 1'b1;
            q.oe_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = q.ready;
    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
    assign mem_addr  = q.addr;
    assign mem_ras_n = q.ras_n;
    assign mem_cas_n = q.cas_n;
    assign mem_we_n  = q.we_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_wdata = q.wdata;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic mem_oe_n
);
    timeunit 1ns; timeprecision 1ps;

    // R9
    p_cas_under_ras_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> !mem_ras_n);

    // R5
    p_we_only_with_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cas_n);

    // R4
    p_precharge_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras_n) |=> mem_ras_n);

    // R6
    p_oe_after_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_cas_n);

    // R6
    p_rsp_follows_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R6
    p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    p_ready_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n)
);

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;
    timeunit 1ns; timeprecision 1ps;

    localparam int PRE   = 3;
    localparam int REF_N = 40;
    localparam int NROW  = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        rsp_valid, rsp_rdata;
    logic [10:0] mem_addr;
    logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_wdata;
    logic        mem_rdata;

    always #10 clk = ~clk;

    dram_page_ctrl #(.PRE_CYC(PRE), .REF_INTERVAL(REF_N)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // ---------------- behavioural cell array with output latch ----------
    bit   cells[int];
    int   row_lat;
    logic dlat = 1'b0;
    logic prev_ras = 1'b1;

    always @(posedge clk) begin
        if (!mem_ras_n && prev_ras) row_lat = int'(mem_addr);
        if (!mem_ras_n && !mem_cas_n) begin
            if (!mem_we_n) cells[row_lat*NROW + int'(mem_addr)] = mem_wdata;
            else dlat <= cells.exists(row_lat*NROW + int'(mem_addr)) ?
                         cells[row_lat*NROW + int'(mem_addr)] : 1'b0;
        end
        prev_ras = mem_ras_n;
    end
    assign mem_rdata = !mem_oe_n ? dlat : 1'b0;

    // ---------------- reference model: expected outputs per cycle -------
    typedef struct {
        bit ras, cas, we, oe;
        int addr;
        bit ca;
        bit wd, cw;
        bit rsp, rd;
        bit ready;
        bit last;
        int tag;
    } frame_t;

    frame_t fq[$];
    frame_t ef;
    bit     shadow[int];
    bit     m_open;
    int     m_row;
    bit     m_pend;
    int     m_refrow;
    int     k;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    function automatic string tagname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8/R10";
        endcase
    endfunction

    function automatic frame_t mk(bit ras, bit cas, bit we, bit oe, int addr, bit ca, int tag);
        frame_t f;
        f.ras = ras; f.cas = cas; f.we = we; f.oe = oe;
        f.addr = addr; f.ca = ca; f.wd = 0; f.cw = 0;
        f.rsp = 0; f.rd = 0; f.ready = 0; f.last = 0; f.tag = tag;
        return f;
    endfunction

    task automatic plan_req(bit w, int a, bit dv);
        int row = a / NROW;
        int col = a % NROW;
        bit hit = m_open && (row == m_row);
        frame_t f;
        if (!hit) begin
            if (m_open) for (int i = 0; i < PRE; i++) fq.push_back(mk(1, 1, 1, 1, 0, 0, 4));
            fq.push_back(mk(0, 1, 1, 1, row, 1, m_open ? 4 : 2));
            m_open = 1;
            m_row  = row;
        end
        f = mk(0, 0, !w, 1, col, 1, w ? 5 : (hit ? 3 : 2));
        f.wd = dv; f.cw = w;
        fq.push_back(f);
        if (w) begin
            shadow[a] = dv;
            f = mk(0, 1, 1, 1, 0, 0, 5); f.last = 1;
            fq.push_back(f);
        end else begin
            fq.push_back(mk(0, 1, 1, 0, 0, 0, 6));
            f = mk(0, 1, 1, 1, 0, 0, 6);
            f.rsp = 1; f.rd = shadow.exists(a) ? shadow[a] : 1'b0; f.last = 1;
            fq.push_back(f);
        end
    endtask

    task automatic plan_ref();
        frame_t f;
        if (m_open) for (int i = 0; i < PRE; i++) fq.push_back(mk(1, 1, 1, 1, 0, 0, 7));
        m_open = 0;
        fq.push_back(mk(0, 1, 1, 1, m_refrow, 1, 7));
        m_refrow = (m_refrow + 1) % NROW;
        for (int i = 0; i < PRE; i++) fq.push_back(mk(1, 1, 1, 1, 0, 0, 7));
        f = mk(1, 1, 1, 1, 0, 0, 7); f.last = 1;
        fq.push_back(f);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            fq.delete();
            m_open = 0; m_row = 0; m_pend = 0; m_refrow = 0; k = 0;
            ef = mk(1, 1, 1, 1, 0, 0, 1);
            ef.ready = 1;
        end else begin
            bit tick, start;
            frame_t f;
            k++;
            tick  = (k % REF_N) == 0;
            start = 0;
            if (fq.size() == 0) begin
                if (req_valid && ef.ready) plan_req(req_write, int'(req_addr), req_wdata);
                else if (m_pend) begin start = 1; plan_ref(); end
            end
            m_pend = tick || (m_pend && !start);
            if (fq.size() != 0) begin
                f = fq.pop_front();
                if (f.last) f.ready = !m_pend;
            end else begin
                f = mk(!m_open, 1, 1, 1, 0, 0, 0);
                f.ready = !m_pend;
            end
            ef = f;
        end
    end

    // ---------------- comparison, away from the active edge -------------
    task automatic chk(logic act, bit exp, string what, int tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d",
                     tagname(tag), what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        chk(mem_ras_n, ef.ras, "mem_ras_n", ef.tag);
        chk(mem_cas_n, ef.cas, "mem_cas_n", ef.tag);
        chk(mem_we_n,  ef.we,  "mem_we_n",  ef.tag);
        chk(mem_oe_n,  ef.oe,  "mem_oe_n",  ef.tag);
        chk(rsp_valid, ef.rsp, "rsp_valid", ef.tag);
        chk(req_ready, ef.ready, "req_ready", ef.ready ? ef.tag : 0);
        if (ef.rsp) chk(rsp_rdata, ef.rd, "rsp_rdata", 6);
        if (ef.cw)  chk(mem_wdata, ef.wd, "mem_wdata", 5);
        if (ef.ca) begin
            n_cmp++;
            if (int'(mem_addr) != ef.addr) begin
                n_bad++;
                $display("FAIL %s mem_addr: actual=%0d expected=%0d at cycle %0d",
                         tagname(ef.tag), mem_addr, ef.addr, cyc);
            end
        end
        // R9: column strobe only under an open row
        n_cmp++;
        if (!mem_cas_n && mem_ras_n) begin
            n_bad++;
            $display("FAIL R9: cas_n=%0b with ras_n=%0b, expected ras_n=0", mem_cas_n, mem_ras_n);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R10: watchdog expired, actual cycles=%0d expected below 150000", cyc);
            summary();
        end
    end

    // ---------------- stimulus ------------------------------------------
    task automatic do_req(bit w, int a, bit dv);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a[21:0];
        req_wdata = dv;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int addr_of(int row, int col);
        return row * NROW + col;
    endfunction

    initial begin
        int lf;
        repeat (4) @(negedge clk);          // R1 checked during reset
        rst_n = 1'b1;
        @(negedge clk);                      // R1 checked after release
        // R2: closed-row read of unwritten bit, then writes/reads
        do_req(0, addr_of(5, 17), 0);
        idle(3);
        do_req(1, addr_of(5, 17), 1);        // R3/R5 page-hit write
        idle(2);
        do_req(0, addr_of(5, 17), 0);        // R3/R6 page-hit read
        idle(4);
        // back-to-back same-row traffic
        do_req(1, addr_of(5, 0), 1);
        do_req(1, addr_of(5, 2047), 1);
        do_req(0, addr_of(5, 0), 0);
        do_req(0, addr_of(5, 2047), 0);
        do_req(0, addr_of(5, 1), 0);
        // R4 row misses at the address corners
        do_req(1, addr_of(2047, 2047), 1);
        do_req(1, addr_of(0, 0), 1);
        do_req(0, addr_of(2047, 2047), 0);
        do_req(0, addr_of(0, 0), 0);
        do_req(0, addr_of(5, 17), 0);
        // R7/R8 idle long enough for several refreshes, open row then closed
        idle(3 * REF_N + 7);
        do_req(0, addr_of(0, 0), 0);
        idle(2 * REF_N);
        // mixed traffic over a few rows; refreshes collide with requests
        lf = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            int row, col;
            bit w;
            lf  = lf ^ (lf << 13);
            lf  = lf ^ (lf >>> 17);
            lf  = lf ^ (lf << 5);
            case ((lf >>> 3) & 3)
                0: row = 5;
                1: row = 6;
                2: row = 2047;
                default: row = 5;
            endcase
            col = (lf >>> 8) & 15;
            w   = ((lf >>> 20) & 1) == 1;
            do_req(w, addr_of(row, col), ((lf >>> 21) & 1) == 1);
            if (((lf >>> 24) & 7) == 0) idle((lf >>> 27) & 7);
        end
        idle(20);
        summary();
    end
endmodule